// File: doc/BRIEF.md
# Shift-Add Constant Multiplier

This block multiplies a 32-bit operand by a constant without a hardware multiplier. It has one shift unit and one adder/subtractor. A short program of step descriptors drives them, one step per clock cycle. Each step reads the running result `y` and replaces it with one of three values:

- `y << n`
- `y + (y << n)`, which multiplies by 2^n + 1
- `(y << n) - y`, which multiplies by 2^n - 1

Chaining these steps reaches composite constants. For example, 45x is built as 5x followed by 9 times that result. The block does not choose the decomposition. Software or a compiler supplies the step program together with the operand and a start strobe.

The running result wraps modulo 2^32, and there is no overflow indication. A program ends either at an end descriptor or after the last step slot. One cycle later, a single-cycle done strobe goes high, and the product is valid in that cycle.

Top module: `shift_add_mult`

## Requirements
- R1: When `start` is high while the block is idle, it captures `operand` and `steps` on that clock edge. The product shown with the following `done` strobe is computed from that captured operand.
- R2: Opcode 2'b00 (shift) replaces the running result `y` with `y << n`.
- R3: Opcode 2'b01 (shift-add) replaces `y` with `y + (y << n)`.
- R4: Opcode 2'b10 (reverse subtract) replaces `y` with `(y << n) - y`.
- R5: Step k sits in `steps[7k+6:7k]`. Its opcode is bits [6:5] of that field and its shift amount `n` is bits [4:0]. Steps run in order from step 0, and each step uses the result of the one before it.
- R6: Opcode 2'b11 (end) leaves the result unchanged and stops the program. If the first end descriptor is step k, `done` is high k+1 cycles after the start edge.
- R7: If no end descriptor appears among the 4 steps, all 4 execute and `done` is high 4 cycles after the start edge.
- R8: `done` is high for exactly one cycle per accepted start.
- R9: Results wrap modulo 2^32, with no overflow signal.
- R10: A `start` strobe while a program is running is ignored. Neither the operand nor the program of the running job changes.
- R11: After reset, `done` is 0 and `product` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| operand | input | 32 | Value to multiply |
| steps | input | 28 | Four 7-bit step descriptors, step 0 in the low bits |
| product | output | 32 | Running result, valid when `done` is high |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions assume two things about the environment:
- `start` is sampled synchronously.
- `steps` is meaningful only on the cycle a start is accepted.

After that cycle the block works only from its captured copy, so the properties relate each step to the latched descriptor rather than to the live port.

The stimulus meets these assumptions in two ways:
- It presents a complete program with each accepted start.
- It raises `start` during a run only in the case written to test that the strobe is ignored.

The vectors cover every opcode, shift amounts of 0 and 31, wrap-around, an immediate end and a full four-step run.

// File: rtl/smul_pkg.sv
package smul_pkg;
   localparam int OP_W = 2;

   typedef enum logic [OP_W-1:0] {
      OP_SHL  = 2'd0,
      OP_ADD  = 2'd1,
      OP_RSUB = 2'd2,
      OP_END  = 2'd3
   } smul_op_e;
endpackage

// File: rtl/smul_step.sv
// One combinational step: a logarithmic barrel shifter feeding an adder/subtractor.
module smul_step
   import smul_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SHIFT_W = 5
) (
   input  logic [DATA_W-1:0]  y,
   input  smul_op_e           op,
   input  logic [SHIFT_W-1:0] sh,
   output logic [DATA_W-1:0]  z
);
   localparam int STAGES = SHIFT_W;

   if (DATA_W < 2) begin : g_bad_width
      $error("smul_step: DATA_W must be at least 2");
   end
   if (SHIFT_W < 1 || (1 << SHIFT_W) > 2 * DATA_W) begin : g_bad_shift
      $error("smul_step: SHIFT_W out of range for DATA_W");
   end

   logic [DATA_W-1:0] stage [STAGES+1];
   assign stage[0] = y;

   // Stage s shifts by 2^s when bit s of the shift amount is set.
   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if ((1 << s) >= DATA_W) begin : g_flush
         assign stage[s+1] = sh[s] ? '0 : stage[s];
      end else begin : g_move
         assign stage[s+1] = sh[s] ? {stage[s][DATA_W-1-(1<<s):0], {(1<<s){1'b0}}}
                                   : stage[s];
      end
   end

   logic [DATA_W-1:0] shifted;
   assign shifted = stage[STAGES];

   always_comb begin
      unique case (op)
         OP_SHL:  z = shifted;
         OP_ADD:  z = y + shifted;
         OP_RSUB: z = shifted - y;
         default: z = y;
      endcase
   end
endmodule

// File: rtl/smul_seq.sv
// Step sequencer: tracks the active slot and issues the completion strobe.
module smul_seq #(
   parameter int MAX_STEPS = 4,
   localparam int IDX_W = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             halt,
   output logic             busy,
   output logic             advance,
   output logic [IDX_W-1:0] idx,
   output logic             done
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(MAX_STEPS - 1);

   if (MAX_STEPS < 1) begin : g_bad_steps
      $error("smul_seq: MAX_STEPS must be at least 1");
   end

   logic finish;
   assign finish  = busy && (halt || idx == LAST);
   assign advance = busy && !halt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
         done <= 1'b0;
      end else if (launch) begin
         busy <= 1'b1;
         idx  <= '0;
         done <= 1'b0;
      end else begin
         done <= finish;
         if (finish) begin
            busy <= 1'b0;
         end else if (busy) begin
            idx <= idx + 1'b1;
         end
      end
   end

   // R8: the completion strobe never lasts two cycles
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: the last slot always ends the run
   a_r7_step_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx == LAST) |=> (done && !busy));
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
   import smul_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int SHIFT_W   = 5,
   parameter int MAX_STEPS = 4,
   localparam int STEP_W   = OP_W + SHIFT_W,
   localparam int PROG_W   = MAX_STEPS * STEP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] operand,
   input  logic [PROG_W-1:0] steps,
   output logic [DATA_W-1:0] product,
   output logic              done
);
   localparam int IDX_W = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1;

   if (STEP_W != OP_W + SHIFT_W) begin : g_bad_layout
      $error("shift_add_mult: descriptor layout mismatch");
   end

   logic              busy, advance, launch;
   logic [IDX_W-1:0]  idx;
   logic [PROG_W-1:0] prog_q;
   logic [DATA_W-1:0] acc, acc_nxt;
   logic [STEP_W-1:0] slot [MAX_STEPS];
   logic [STEP_W-1:0] cur;
   smul_op_e          cur_op;
   logic [SHIFT_W-1:0] cur_sh;

   assign launch = start && !busy;

   for (genvar k = 0; k < MAX_STEPS; k++) begin : g_slot
      assign slot[k] = prog_q[k*STEP_W +: STEP_W];
   end

   assign cur    = slot[idx];
   assign cur_op = smul_op_e'(cur[STEP_W-1 -: OP_W]);
   assign cur_sh = cur[SHIFT_W-1:0];

   smul_seq #(.MAX_STEPS(MAX_STEPS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch  (launch),
      .halt    (cur_op == OP_END),
      .busy    (busy),
      .advance (advance),
      .idx     (idx),
      .done    (done)
   );

   smul_step #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_step (
      .y  (acc),
      .op (cur_op),
      .sh (cur_sh),
      .z  (acc_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc    <= '0;
         prog_q <= '0;
      end else if (launch) begin
         acc    <= operand;
         prog_q <= steps;
      end else if (advance) begin
         acc    <= acc_nxt;
      end
   end

   assign product = acc;

   // R1: an accepted start loads the operand
   a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (acc == $past(operand)));

   // R2: shift step
   a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cur_op == OP_SHL) |=> (acc == ($past(acc) << $past(cur_sh))));

   // R3: shift-add step
   a_r3_add: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cur_op == OP_ADD) |=>
         (acc == $past(acc) + ($past(acc) << $past(cur_sh))));

   // R4: reverse subtract step
   a_r4_rsub: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cur_op == OP_RSUB) |=>
         (acc == ($past(acc) << $past(cur_sh)) - $past(acc)));

   // R6: end descriptor finishes without touching the result
   a_r6_end_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cur_op == OP_END) |=> (done && $stable(acc)));

   // R10: a start during a run leaves the captured program alone
   a_r10_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> $stable(prog_q));
endmodule

// File: tb/shift_add_mult_tb.sv
module shift_add_mult_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] operand = '0;
   logic [27:0] steps = '0;
   logic [31:0] product;
   logic        done;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   shift_add_mult u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
      .steps(steps), .product(product), .done(done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Descriptor: {opcode[1:0], shift[4:0]}; 00 shift, 01 add, 10 rsub, 11 end
   localparam logic [6:0] SE = {2'b11, 5'd0};

   localparam logic [31:0] V_OP [NV] = '{
      32'd7, 32'd3, 32'd10, 32'd5, 32'h1234, 32'hFFFF_FFFF, 32'd99, 32'd3 };
   localparam logic [27:0] V_PROG [NV] = '{
      {SE, SE, {2'b01,5'd1}, {2'b00,5'd1}},
      {SE, SE, {2'b01,5'd3}, {2'b01,5'd2}},
      {SE, SE, SE, {2'b10,5'd3}},
      {{2'b00,5'd1}, {2'b00,5'd1}, {2'b00,5'd1}, {2'b00,5'd1}},
      {SE, SE, SE, SE},
      {SE, SE, SE, {2'b01,5'd4}},
      {SE, SE, SE, {2'b10,5'd0}},
      {{2'b10,5'd1}, {2'b01,5'd1}, {2'b00,5'd31}, {2'b10,5'd2}} };
   localparam logic [31:0] V_EXP [NV] = '{
      32'd42, 32'd135, 32'd70, 32'd80, 32'h1234, 32'hFFFF_FFEF, 32'd0, 32'h8000_0000 };
   localparam int V_LAT [NV] = '{3, 3, 2, 4, 1, 2, 2, 4};
   localparam string V_TAG [NV] = '{
      "R2/R3/R5 x6", "R3/R5 x45", "R4 x7", "R7 four shifts",
      "R6 immediate end", "R9 wrap", "R4 rsub n=0", "R7/R9 shift 31" };

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Launch a job, optionally raise start again during the run with other data.
   task automatic run(input logic [31:0] x, input logic [27:0] p,
                      input logic [31:0] exp, input int lat, input string tag,
                      input bit poke);
      int cnt;
      @(negedge clk);
      operand = x; steps = p; start = 1'b1;
      @(negedge clk);
      if (poke) begin
         operand = 32'd100; steps = {SE, SE, SE, SE};
      end else begin
         start = 1'b0;
      end
      cnt = 0;
      while (cnt < 20) begin
         @(negedge clk);
         start = 1'b0;
         cnt++;
         if (done) break;
      end
      check(cnt == lat, {tag, " latency"}, 32'(cnt), 32'(lat));
      check(product == exp, {tag, " product R1"}, product, exp);
      @(negedge clk);
      check(done == 1'b0, {tag, " R8 single pulse"}, 32'(done), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check(done == 1'b0, "R11 done after reset", 32'(done), 32'd0);
      check(product == 32'd0, "R11 product after reset", product, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         run(V_OP[i], V_PROG[i], V_EXP[i], V_LAT[i], V_TAG[i], 1'b0);
      end

      // R10: start while busy is ignored; the first job completes unchanged
      run(32'd2, {{2'b00,5'd1}, {2'b00,5'd1}, {2'b00,5'd1}, {2'b00,5'd1}},
          32'd32, 4, "R10 start while busy", 1'b1);

      // R1: back-to-back jobs each use their own operand
      run(32'd11, {SE, SE, SE, {2'b01,5'd0}}, 32'd22, 2, "R1/R3 n=0 doubles", 1'b0);

      // R5: order matters, shift after subtract
      run(32'd4, {SE, SE, {2'b00,5'd2}, {2'b10,5'd1}}, 32'd16, 3, "R5 step order", 1'b0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule